// File: doc/BRIEF.md
# Planar Intra Prediction Sample Generator

This block forms the planar intra prediction for a square 8-bit luma block whose edge is 4, 8, 16 or 32 samples. Software or an upstream fetch stage fills an internal neighbour buffer of 4*nt+1 samples through a write port. It then pulses `start` with a 2-bit size code. The block streams out one predicted sample per handshake beat. Each beat carries its row and column index.

Each sample is a bilinear blend of four neighbours: the left neighbour of its row, the top neighbour of its column, one shared top-right sample and one shared bottom-left sample. The weights depend on the sample's position. A rounding term of nt is added, and the sum is shifted right by log2(nt)+1. Sizes 8 and above are emitted as 8x8 tiles. The tiles sweep across the columns of one 8-row band before moving down to the next band. Size 4 is emitted as four rows of four samples.

A three-state controller sequences the work. ST_IDLE moves to ST_STREAM when `start` is accepted. ST_STREAM moves to ST_FINISH when the final sample is accepted. ST_FINISH always returns to ST_IDLE after one cycle.

Top module: `planar_pred`

## Requirements
- R1: Each sample at column x, row y equals ((nt-1-x)*L + (x+1)*TR + (nt-1-y)*T + (y+1)*BL + nt) >> (log2(nt)+1), truncated to 8 bits.
- R2: The buffer index 2*nt-1-y gives L for row y. Index 2*nt+1+x gives T for column x. Index 3*nt+1 gives TR, and index nt-1 gives BL.
- R3: `size_code` is latched at an accepted start: 0 selects nt=4, 1 selects 8, 2 selects 16 and 3 selects 32. Exactly nt*nt samples follow, each with a row and column below nt.
- R4: For nt=4, samples leave in row-major order: rows 0..3, and columns 0..3 within each row.
- R5: For nt of 8 or more, samples leave in 8x8 tiles. Within a tile the order is row-major. Tiles advance across the columns of an 8-row band, then down to the next band. The first sample is row 0, column 0.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sample`, `out_row` and `out_col` hold their values.
- R7: `done` is high for exactly one cycle, the cycle after the final sample is accepted. `out_valid` is low during that cycle, and `busy` is low in the cycle after it.
- R8: A `start` that arrives while `busy` is high is ignored. The running job keeps its size and sequence.
- R9: Writes to the neighbour buffer while `busy` is high are discarded. Neither the running job nor later jobs see them.
- R10: After reset, `busy`, `out_valid` and `done` are low.
- R11: A buffer that is all 0 yields samples of 0, and a buffer that is all 255 yields samples of 255, for every size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_we | input | 1 | Neighbour buffer write enable |
| ref_addr | input | 8 | Neighbour buffer write index |
| ref_wdata | input | 8 | Neighbour sample to write |
| start | input | 1 | Start pulse, accepted only when idle |
| size_code | input | 2 | Block size select: 0=4, 1=8, 2=16, 3=32 |
| busy | output | 1 | A job is in progress |
| out_valid | output | 1 | Output beat is valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_sample | output | 8 | Predicted sample |
| out_row | output | 5 | Row index of the sample |
| out_col | output | 5 | Column index of the sample |
| done | output | 1 | One-cycle pulse after the last sample |

## Verification
The bound checker watches the handshake on every cycle. It checks that a stalled beat holds steady, that `done` is a lone pulse with no valid beside it, and that valid never appears outside a job. It also checks that the latched size stays fixed through a job, that every tag stays inside the block, and that each job opens at row 0, column 0.

The arithmetic, the neighbour index mapping and the exact tile order can only be shown by the bench. It compares each accepted beat against a behavioural model over random and saturated buffers for all four sizes. The bench's scenarios also show that starts and writes arriving mid-job are ignored, with a follow-up job run on the untouched buffer.

// File: rtl/planar_pkg.sv
`timescale 1ns/1ps
package planar_pkg;

    // Controller states of the sample walker.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_FINISH = 2'd2
    } walk_state_e;

    // log2 of the smallest supported block edge (size code 0).
    localparam int unsigned LOG_MIN_NT = 2;

    // Number of weighted neighbour terms in a planar sum.
    localparam int unsigned N_TERMS = 4;

endpackage

// File: rtl/planar_refbuf.sv
`timescale 1ns/1ps
module planar_refbuf #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 129,
    parameter int unsigned AW    = 8,
    parameter int unsigned NRD   = 4
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic [NRD-1:0][AW-1:0]   rd_addr,
    output logic [NRD-1:0][DW-1:0]   rd_data
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_addr) < DEPTH)) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // One asynchronous read port per neighbour term.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = (32'(rd_addr[p]) < DEPTH) ? cells[rd_addr[p]] : '0;
    end

endmodule

// File: rtl/planar_blend.sv
`timescale 1ns/1ps
module planar_blend
    import planar_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned ACC_W = 16,
    parameter int unsigned CW    = 5,
    parameter int unsigned NT_W  = 6,
    parameter int unsigned SH_W  = 3
) (
    input  logic [NT_W-1:0] nt,
    input  logic [SH_W-1:0] shift,
    input  logic [CW-1:0]   pos_x,
    input  logic [CW-1:0]   pos_y,
    input  logic [DW-1:0]   left_s,
    input  logic [DW-1:0]   top_s,
    input  logic [DW-1:0]   tr_s,
    input  logic [DW-1:0]   bl_s,
    output logic [DW-1:0]   sample
);

    logic [N_TERMS-1:0][ACC_W-1:0] weight;
    logic [N_TERMS-1:0][ACC_W-1:0] nbr;
    logic [N_TERMS-1:0][ACC_W-1:0] prod;
    logic [ACC_W-1:0]              acc;

    // Column weights pair with the row neighbour and the top-right corner;
    // row weights pair with the column neighbour and the bottom-left corner.
    assign weight[0] = ACC_W'(nt) - ACC_W'(1) - ACC_W'(pos_x);
    assign weight[1] = ACC_W'(pos_x) + ACC_W'(1);
    assign weight[2] = ACC_W'(nt) - ACC_W'(1) - ACC_W'(pos_y);
    assign weight[3] = ACC_W'(pos_y) + ACC_W'(1);

    assign nbr[0] = ACC_W'(left_s);
    assign nbr[1] = ACC_W'(tr_s);
    assign nbr[2] = ACC_W'(top_s);
    assign nbr[3] = ACC_W'(bl_s);

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        assign prod[t] = weight[t] * nbr[t];
    end

    always_comb begin
        acc = ACC_W'(nt);
        for (int t = 0; t < N_TERMS; t++) begin
            acc = acc + prod[t];
        end
    end

    assign sample = DW'(acc >> shift);

endmodule

// File: rtl/planar_walk.sv
`timescale 1ns/1ps
module planar_walk
    import planar_pkg::*;
#(
    parameter int unsigned MAX_NT = 32,
    parameter int unsigned TILE   = 8,
    parameter int unsigned CW     = $clog2(MAX_NT),
    parameter int unsigned NT_W   = CW + 1,
    parameter int unsigned SH_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_req,
    input  logic [1:0]      size_sel,
    input  logic            advance,
    output logic            busy,
    output logic            valid,
    output logic            done,
    output logic [CW-1:0]   pos_x,
    output logic [CW-1:0]   pos_y,
    output logic [NT_W-1:0] nt_o,
    output logic [SH_W-1:0] shift_o
);

    localparam int unsigned TW  = $clog2(TILE);
    localparam int unsigned TIW = CW - TW;

    walk_state_e       state_q, state_d;
    logic [1:0]        code_q;
    logic [TW-1:0]     rx_q, ry_q;
    logic [TIW-1:0]    tx_q, by_q;

    logic [3:0]        lg_nt, lg_span;
    logic [TW:0]       span;
    logic [TW-1:0]     span_m1;
    logic [TIW:0]      tiles;
    logic [TIW-1:0]    tile_m1;
    logic              fire, end_rx, end_ry, end_tx, end_by, final_beat;

    // Size derivation: an edge smaller than a tile becomes one narrow tile.
    assign lg_nt   = 4'(code_q) + 4'(LOG_MIN_NT);
    assign lg_span = (lg_nt < 4'(TW)) ? lg_nt : 4'(TW);
    assign span    = (TW+1)'(1) << lg_span;
    assign span_m1 = TW'(span - (TW+1)'(1));
    assign tiles   = (TIW+1)'(1) << (lg_nt - lg_span);
    assign tile_m1 = TIW'(tiles - (TIW+1)'(1));

    assign fire       = (state_q == ST_STREAM) && advance;
    assign end_rx     = (rx_q == span_m1);
    assign end_ry     = (ry_q == span_m1);
    assign end_tx     = (tx_q == tile_m1);
    assign end_by     = (by_q == tile_m1);
    assign final_beat = end_rx && end_ry && end_tx && end_by;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_req)          state_d = ST_STREAM;
            ST_STREAM: if (fire && final_beat) state_d = ST_FINISH;
            ST_FINISH:                         state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Size latch and tile walk counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            rx_q   <= '0;
            ry_q   <= '0;
            tx_q   <= '0;
            by_q   <= '0;
        end else if ((state_q == ST_IDLE) && start_req) begin
            code_q <= size_sel;
            rx_q   <= '0;
            ry_q   <= '0;
            tx_q   <= '0;
            by_q   <= '0;
        end else if (fire && !final_beat) begin
            if (!end_rx) begin
                rx_q <= rx_q + TW'(1);
            end else begin
                rx_q <= '0;
                if (!end_ry) begin
                    ry_q <= ry_q + TW'(1);
                end else begin
                    ry_q <= '0;
                    if (!end_tx) begin
                        tx_q <= tx_q + TIW'(1);
                    end else begin
                        tx_q <= '0;
                        by_q <= by_q + TIW'(1);
                    end
                end
            end
        end
    end

    // Outputs decoded from state and counters.
    always_comb begin
        busy    = (state_q != ST_IDLE);
        valid   = (state_q == ST_STREAM);
        done    = (state_q == ST_FINISH);
        pos_x   = {tx_q, rx_q};
        pos_y   = {by_q, ry_q};
        nt_o    = NT_W'(1) << lg_nt;
        shift_o = SH_W'(lg_nt + 4'd1);
    end

endmodule

// File: rtl/planar_pred.sv
`timescale 1ns/1ps
module planar_pred
    import planar_pkg::*;
#(
    parameter  int unsigned MAX_NT = 32,
    parameter  int unsigned DW     = 8,
    parameter  int unsigned ACC_W  = 16,
    parameter  int unsigned TILE   = 8,
    localparam int unsigned CW     = $clog2(MAX_NT),
    localparam int unsigned NT_W   = CW + 1,
    localparam int unsigned DEPTH  = 4 * MAX_NT + 1,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned SH_W   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_we,
    input  logic [AW-1:0] ref_addr,
    input  logic [DW-1:0] ref_wdata,
    input  logic          start,
    input  logic [1:0]    size_code,
    output logic          busy,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_sample,
    output logic [CW-1:0] out_row,
    output logic [CW-1:0] out_col,
    output logic          done
);

    logic [NT_W-1:0]              blk_nt;
    logic [SH_W-1:0]              blk_shift;
    logic [CW-1:0]                pos_x, pos_y;
    logic [N_TERMS-1:0][AW-1:0]   rd_addr;
    logic [N_TERMS-1:0][DW-1:0]   rd_data;
    logic [AW-1:0]                nt_a;
    logic                         wr_ok;

    planar_walk #(
        .MAX_NT (MAX_NT),
        .TILE   (TILE),
        .CW     (CW),
        .NT_W   (NT_W),
        .SH_W   (SH_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start),
        .size_sel  (size_code),
        .advance   (out_ready),
        .busy      (busy),
        .valid     (out_valid),
        .done      (done),
        .pos_x     (pos_x),
        .pos_y     (pos_y),
        .nt_o      (blk_nt),
        .shift_o   (blk_shift)
    );

    // Buffer contents are frozen while a job runs.
    assign wr_ok = ref_we && !busy;
    assign nt_a  = AW'(blk_nt);

    assign rd_addr[0] = (nt_a << 1) - AW'(1) - AW'(pos_y);  // row neighbour
    assign rd_addr[1] = (nt_a << 1) + nt_a + AW'(1);         // top-right
    assign rd_addr[2] = (nt_a << 1) + AW'(1) + AW'(pos_x);  // column neighbour
    assign rd_addr[3] = nt_a - AW'(1);                       // bottom-left

    planar_refbuf #(
        .DW    (DW),
        .DEPTH (DEPTH),
        .AW    (AW),
        .NRD   (N_TERMS)
    ) u_buf (
        .clk     (clk),
        .wr_en   (wr_ok),
        .wr_addr (ref_addr),
        .wr_data (ref_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    planar_blend #(
        .DW    (DW),
        .ACC_W (ACC_W),
        .CW    (CW),
        .NT_W  (NT_W),
        .SH_W  (SH_W)
    ) u_blend (
        .nt     (blk_nt),
        .shift  (blk_shift),
        .pos_x  (pos_x),
        .pos_y  (pos_y),
        .left_s (rd_data[0]),
        .top_s  (rd_data[2]),
        .tr_s   (rd_data[1]),
        .bl_s   (rd_data[3]),
        .sample (out_sample)
    );

    assign out_row = pos_y;
    assign out_col = pos_x;

endmodule

// File: rtl/planar_chk.sv
`timescale 1ns/1ps
module planar_chk #(
    parameter int unsigned CW   = 5,
    parameter int unsigned NT_W = 6,
    parameter int unsigned DW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            out_valid,
    input logic            out_ready,
    input logic            done,
    input logic [DW-1:0]   out_sample,
    input logic [CW-1:0]   out_row,
    input logic [CW-1:0]   out_col,
    input logic [NT_W-1:0] blk_nt
);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)
                                       && $stable(out_row) && $stable(out_col)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    assert_valid_in_job_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    assert_size_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(blk_nt));

    assert_tag_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (NT_W'(out_row) < blk_nt) && (NT_W'(out_col) < blk_nt));

    assert_first_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_row == '0) && (out_col == '0));

endmodule

bind planar_pred planar_chk #(
    .CW   (CW),
    .NT_W (NT_W),
    .DW   (DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .done       (done),
    .out_sample (out_sample),
    .out_row    (out_row),
    .out_col    (out_col),
    .blk_nt     (blk_nt)
);

// File: tb/planar_pred_test.sv
`timescale 1ns/1ps
module planar_pred_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_we = 1'b0;
    logic [7:0] ref_addr = '0;
    logic [7:0] ref_wdata = '0;
    logic       start = 1'b0;
    logic [1:0] size_code = '0;
    logic       busy, out_valid, done;
    logic       out_ready = 1'b0;
    logic [7:0] out_sample;
    logic [4:0] out_row, out_col;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int refm [0:128];

    always #2.5 clk = ~clk;

    planar_pred uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_we     (ref_we),
        .ref_addr   (ref_addr),
        .ref_wdata  (ref_wdata),
        .start      (start),
        .size_code  (size_code),
        .busy       (busy),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_sample (out_sample),
        .out_row    (out_row),
        .out_col    (out_col),
        .done       (done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model(input int x, input int y, input int nt);
        int sum;
        sum = (nt-1-x) * refm[2*nt-1-y] + (x+1) * refm[3*nt+1]
            + (nt-1-y) * refm[2*nt+1+x] + (y+1) * refm[nt-1] + nt;
        return (sum >> ($clog2(nt) + 1)) & 255;
    endfunction

    task automatic load_buf(input int nt);
        for (int i = 0; i <= 4*nt; i++) begin
            @(negedge clk);
            ref_we = 1'b1; ref_addr = 8'(i); ref_wdata = 8'(refm[i]);
        end
        @(negedge clk);
        ref_we = 1'b0;
    endtask

    task automatic fill(input int mode);
        for (int i = 0; i < 129; i++) begin
            refm[i] = (mode == 0) ? 0 : (mode == 1) ? 255 : int'($urandom % 256);
        end
    endtask

    task automatic run_job(input int code, input bit inject, input bit rnd_ready,
                           input string vtag);
        int nt = 4 << code;
        int qr[$];
        int qc[$];
        int beats = 0;
        bit fin = 1'b0;
        string otag;
        otag = (nt == 4) ? "R4" : "R5";
        if (nt == 4) begin
            for (int y = 0; y < 4; y++)
                for (int x = 0; x < 4; x++) begin qr.push_back(y); qc.push_back(x); end
        end else begin
            for (int b = 0; b < nt/8; b++)
                for (int t = 0; t < nt/8; t++)
                    for (int r = 0; r < 8; r++)
                        for (int c = 0; c < 8; c++) begin
                            qr.push_back(b*8 + r); qc.push_back(t*8 + c);
                        end
        end
        @(negedge clk);
        start = 1'b1; size_code = 2'(code);
        @(negedge clk);
        start = 1'b0;
        for (int it = 0; it < 20000 && !fin; it++) begin
            if (inject && it == 3) begin
                // R8/R9: mid-job start with another size and a buffer write
                ref_we = 1'b1; ref_addr = 8'(2*nt+1); ref_wdata = 8'(~refm[2*nt+1]);
                start = 1'b1; size_code = 2'((code + 1) % 4);
            end else begin
                ref_we = 1'b0; start = 1'b0;
            end
            out_ready = rnd_ready ? (($urandom % 3) != 0) : 1'b1;
            if (out_valid && out_ready) begin
                if (qr.size() == 0) begin
                    check(1'b0, "R3 extra beat", beats, nt*nt);
                end else begin
                    check(out_row == 5'(qr[0]) && out_col == 5'(qc[0]), {otag, " order row*64+col"},
                          int'(out_row)*64 + int'(out_col), qr[0]*64 + qc[0]);
                    check(int'(out_sample) == model(qc[0], qr[0], nt), {vtag, " sample value"},
                          int'(out_sample), model(qc[0], qr[0], nt));
                    void'(qr.pop_front());
                    void'(qc.pop_front());
                end
                beats++;
            end
            if (done) begin
                check(!out_valid, "R7 valid during done", int'(out_valid), 0);
                check(beats == nt*nt, "R3 beat count", beats, nt*nt);
                fin = 1'b1;
            end
            @(negedge clk);
        end
        ref_we = 1'b0; start = 1'b0; out_ready = 1'b0;
        check(fin, "R7 done seen", int'(fin), 1);
        check(!busy && !done, "R7 idle after done", int'(busy) + int'(done), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(!busy && !out_valid && !done, "R10 reset outputs",
              int'(busy) + int'(out_valid) + int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !out_valid && !done, "R10 after release",
              int'(busy) + int'(out_valid) + int'(done), 0);

        fill(2); load_buf(4);  run_job(0, 1'b0, 1'b0, "R1/R2");
        fill(2); load_buf(8);  run_job(1, 1'b0, 1'b1, "R1/R2");
        fill(2); load_buf(16); run_job(2, 1'b0, 1'b1, "R1/R2");
        fill(2); load_buf(32); run_job(3, 1'b1, 1'b1, "R1/R8/R9");
        run_job(3, 1'b0, 1'b1, "R9 rerun");
        run_job(0, 1'b1, 1'b0, "R9 small");
        fill(0); load_buf(8);  run_job(1, 1'b0, 1'b0, "R11 zero");
        fill(1); load_buf(32); run_job(3, 1'b0, 1'b1, "R11 full");
        fill(1); load_buf(4);  run_job(0, 1'b0, 1'b1, "R11 full");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule